// File: doc/BRIEF.md
# Shift, Rotate and Bit-Manipulation Unit

This unit performs the single-operand operations on a 16-bit value. It covers circular rotates, rotates through the carry, left and right shifts, one's complement and two's complement. It also tests, flips, clears or sets any one bit chosen by a 4-bit index. A caller presents an operand, a carry-in, a 4-bit operation code and a bit index, with a valid strobe. One clock later the unit returns the result, a carry-out, zero, sign and overflow indications, and a write-enable. The write-enable tells the register file whether the result is to be stored.

The naming differs from the familiar convention. The plain rotate codes are circular and the through-carry rotate codes feed the carry-in into the vacated bit. The two left-shift codes give identical results. The bit-test code only produces flags and never asks for a write. Decode, register storage and 32-bit operands belong to the surrounding core.

Operation codes are as follows. 0000 is circular left and 0001 is left through carry. 0010 is circular right and 0011 is right through carry. 0100 and 0101 are the two left shifts. 0110 is the arithmetic right shift and 0111 is the logical right shift. 1000 is complement and 1001 is negate. 1010 and 1011 are reserved. 1100 tests a bit, 1101 flips it, 1110 clears it and 1111 sets it.

Top module: `bitop_unit`

## Requirements
- R1: While rst_n is low, out_vld_o, wr_en_o, res_o, cout_o, zero_o, sign_o and ovf_o are all 0.
- R2: The outputs for an operation appear on the first rising edge after in_vld_i is sampled high, with out_vld_o high for that one cycle. A cycle with in_vld_i low drives out_vld_o low and leaves res_o and the flags unchanged.
- R3: Code 0000 rotates left circularly and code 0010 rotates right circularly. cout_o is the bit that moved across the end: bit 15 for the left rotate, bit 0 for the right rotate.
- R4: Code 0001 shifts left and puts cin_i into bit 0. Code 0011 shifts right and puts cin_i into bit 15. cout_o is the bit shifted out: old bit 15 for the left shift, old bit 0 for the right shift.
- R5: Codes 0100 and 0101 give identical results. Both shift left with a 0 into bit 0, and cout_o is the old bit 15.
- R6: Code 0110 shifts right and copies old bit 15 into bit 15. Code 0111 shifts right with a 0 into bit 15. In both, cout_o is the old bit 0.
- R7: Code 1000 returns the bitwise inverse of the operand with cout_o equal to cin_i.
- R8: Code 1001 returns the two's complement of the operand. cout_o is 1 exactly when the operand is nonzero. ovf_o is 1 only for operand 0x8000, whose result is 0x8000.
- R9: Code 1100 returns the operand unchanged with wr_en_o low and cout_o equal to cin_i. zero_o is 1 exactly when operand bit idx_i is 0, and sign_o is 0.
- R10: Codes 1101, 1110 and 1111 act on operand bit idx_i, for any index from 0 to 15. 1101 inverts the bit, 1110 forces it to 0 and 1111 forces it to 1. All other bits are unchanged, and cout_o equals cin_i.
- R11: For every code except 1100, zero_o is 1 exactly when res_o is 0 and sign_o equals res_o bit 15. ovf_o is 0 for every code except 1001.
- R12: wr_en_o is 1 for all codes except 1100, 1010 and 1011. The reserved codes 1010 and 1011 return the operand unchanged with cout_o equal to cin_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | 1 | Operation request strobe |
| op_i | input | 4 | Operation code |
| opd_i | input | 16 | Operand |
| cin_i | input | 1 | Carry-in |
| idx_i | input | 4 | Bit index for bit operations |
| out_vld_o | output | 1 | Result valid, one cycle after the request |
| res_o | output | 16 | Result |
| cout_o | output | 1 | Carry-out |
| zero_o | output | 1 | Zero indication |
| sign_o | output | 1 | Sign indication |
| ovf_o | output | 1 | Overflow indication |
| wr_en_o | output | 1 | Result should be stored |

## Verification
The hardest cases are the ones where a single operand value or a single bit position decides the outcome. Examples are negate of 0x8000 and of zero, and bit operations on index 15 or index 0 combined with operands whose selected bit is already in the target state. The stimulus reaches these by pairing every operation code with a fixed list of edge operands (0, 1, 0x7FFF, 0x8000, 0xFFFF and neighbours) and with a pseudo-random operand set. The bit index steps by 7 modulo 16, so every index meets every code. The carry-in alternates so that each through-carry and pass-through path sees both values.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [3:0] {
    OP_ROL   = 4'h0,
    OP_RCL   = 4'h1,
    OP_ROR   = 4'h2,
    OP_RCR   = 4'h3,
    OP_SHLA  = 4'h4,
    OP_SHLL  = 4'h5,
    OP_SHRA  = 4'h6,
    OP_SHRL  = 4'h7,
    OP_INV   = 4'h8,
    OP_NEG   = 4'h9,
    OP_RSV0  = 4'hA,
    OP_RSV1  = 4'hB,
    OP_BTST  = 4'hC,
    OP_BFLIP = 4'hD,
    OP_BCLR  = 4'hE,
    OP_BSET  = 4'hF
  } bitop_e;

  typedef struct packed {
    logic cout;
    logic zero;
    logic sign;
    logic ovf;
    logic wr;
  } bitop_flags_t;
endpackage

// File: rtl/bitop_shift.sv
module bitop_shift #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  logic [2:0]   sel_i,
  output logic [W-1:0] y_o,
  output logic         cout_o
);
  localparam int MSB = W - 1;

  always_comb begin
    y_o    = a_i;
    cout_o = 1'b0;
    unique case (sel_i)
      3'b000: begin y_o = {a_i[MSB-1:0], a_i[MSB]}; cout_o = a_i[MSB]; end
      3'b001: begin y_o = {a_i[MSB-1:0], cin_i};    cout_o = a_i[MSB]; end
      3'b010: begin y_o = {a_i[0], a_i[MSB:1]};     cout_o = a_i[0];   end
      3'b011: begin y_o = {cin_i, a_i[MSB:1]};      cout_o = a_i[0];   end
      3'b100,
      3'b101: begin y_o = {a_i[MSB-1:0], 1'b0};     cout_o = a_i[MSB]; end
      3'b110: begin y_o = {a_i[MSB], a_i[MSB:1]};   cout_o = a_i[0];   end
      default: begin y_o = {1'b0, a_i[MSB:1]};      cout_o = a_i[0];   end
    endcase
  end
endmodule

// File: rtl/bitop_compl.sv
module bitop_compl #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  logic         neg_i,
  output logic [W-1:0] y_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] inv;
  logic         nz;

  assign inv = ~a_i;
  assign nz  = |a_i;

  always_comb begin
    if (neg_i) begin
      y_o    = inv + {{(W-1){1'b0}}, 1'b1};
      cout_o = nz;
      ovf_o  = (a_i == MIN_NEG);
    end else begin
      y_o    = inv;
      cout_o = cin_i;
      ovf_o  = 1'b0;
    end
  end
endmodule

// File: rtl/bitop_bitmod.sv
module bitop_bitmod #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     a_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       mode_i,
  output logic [W-1:0]     y_o,
  output logic             bit_o
);
  logic [W-1:0] mask;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask[g] = (idx_i == IDX_W'(g));
  end

  assign bit_o = |(a_i & mask);

  always_comb begin
    unique case (mode_i)
      2'b01:   y_o = a_i ^ mask;
      2'b10:   y_o = a_i & ~mask;
      2'b11:   y_o = a_i | mask;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld_i,
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     opd_i,
  input  logic             cin_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             out_vld_o,
  output logic [W-1:0]     res_o,
  output logic             cout_o,
  output logic             zero_o,
  output logic             sign_o,
  output logic             ovf_o,
  output logic             wr_en_o
);
  bitop_e op;
  assign op = bitop_e'(op_i);

  logic [W-1:0] sh_y, cp_y, bm_y;
  logic         sh_c, cp_c, cp_v, bm_bit;

  bitop_shift #(.W(W)) u_shift (
    .a_i(opd_i), .cin_i(cin_i), .sel_i(op_i[2:0]),
    .y_o(sh_y), .cout_o(sh_c)
  );

  bitop_compl #(.W(W)) u_compl (
    .a_i(opd_i), .cin_i(cin_i), .neg_i(op_i[0]),
    .y_o(cp_y), .cout_o(cp_c), .ovf_o(cp_v)
  );

  bitop_bitmod #(.W(W), .IDX_W(IDX_W)) u_bitmod (
    .a_i(opd_i), .idx_i(idx_i), .mode_i(op_i[1:0]),
    .y_o(bm_y), .bit_o(bm_bit)
  );

  logic [W-1:0] res_d;
  bitop_flags_t fl_d;

  always_comb begin
    res_d   = opd_i;
    fl_d    = '0;
    fl_d.wr = 1'b1;
    unique case (op)
      OP_INV, OP_NEG: begin
        res_d     = cp_y;
        fl_d.cout = cp_c;
        fl_d.ovf  = cp_v;
      end
      OP_RSV0, OP_RSV1: begin
        res_d     = opd_i;
        fl_d.cout = cin_i;
        fl_d.wr   = 1'b0;
      end
      OP_BTST, OP_BFLIP, OP_BCLR, OP_BSET: begin
        res_d     = bm_y;
        fl_d.cout = cin_i;
        fl_d.wr   = (op != OP_BTST);
      end
      default: begin
        res_d     = sh_y;
        fl_d.cout = sh_c;
      end
    endcase
    if (op == OP_BTST) begin
      fl_d.zero = ~bm_bit;
      fl_d.sign = 1'b0;
    end else begin
      fl_d.zero = (res_d == '0);
      fl_d.sign = res_d[W-1];
    end
  end

  logic [W-1:0] res_q;
  bitop_flags_t fl_q;
  logic         vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      fl_q  <= '0;
    end else begin
      vld_q <= in_vld_i;
      if (in_vld_i) begin
        res_q <= res_d;
        fl_q  <= fl_d;
      end
    end
  end

  assign out_vld_o = vld_q;
  assign res_o     = res_q;
  assign cout_o    = fl_q.cout;
  assign zero_o    = fl_q.zero;
  assign sign_o    = fl_q.sign;
  assign ovf_o     = fl_q.ovf;
  assign wr_en_o   = fl_q.wr & vld_q;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld_i,
  input logic [3:0]       op_i,
  input logic [W-1:0]     opd_i,
  input logic             cin_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             out_vld_o,
  input logic [W-1:0]     res_o,
  input logic             cout_o,
  input logic             zero_o,
  input logic             sign_o,
  input logic             ovf_o,
  input logic             wr_en_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld_i |=> out_vld_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld_i |=> (!out_vld_o && $stable(res_o)));

  // R9
  test_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && op_i == 4'hC) |=> (!wr_en_o && res_o == $past(opd_i)));

  // R8
  neg_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && op_i == 4'h9 && opd_i == MIN_NEG) |=> (ovf_o && res_o == MIN_NEG));

  // R6
  sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && op_i == 4'h6) |=> (res_o[W-1] == $past(opd_i[W-1]) && cout_o == $past(opd_i[0])));

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (zero_o == (res_o == '0) && sign_o == res_o[W-1]));
endmodule

bind bitop_unit bitop_unit_chk #(.W(W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_bitop_unit.sv
`timescale 1ns/1ps
module tb_bitop_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld_i;
  logic [3:0]  op_i;
  logic [15:0] opd_i;
  logic        cin_i;
  logic [3:0]  idx_i;
  logic        out_vld_o, cout_o, zero_o, sign_o, ovf_o, wr_en_o;
  logic [15:0] res_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bitop_unit dut (
    .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld_i), .op_i(op_i),
    .opd_i(opd_i), .cin_i(cin_i), .idx_i(idx_i), .out_vld_o(out_vld_o),
    .res_o(res_o), .cout_o(cout_o), .zero_o(zero_o), .sign_o(sign_o),
    .ovf_o(ovf_o), .wr_en_o(wr_en_o)
  );

  function automatic string tag_of(int op);
    case (op)
      0, 2:    return "R3";
      1, 3:    return "R4";
      4, 5:    return "R5";
      6, 7:    return "R6";
      8:       return "R7";
      9:       return "R8";
      10, 11:  return "R12";
      12:      return "R9";
      default: return "R10";
    endcase
  endfunction

  // expected {res, cout, zero, sign, ovf, wr}
  function automatic logic [20:0] model(int op, int a, int c, int ix);
    int r, co, z, s, v, w, p, b;
    r = a; co = c; v = 0; w = 1;
    p = 1 << ix;
    b = (a / p) % 2;
    case (op)
      0: begin r = (a * 2) % 65536 + a / 32768; co = a / 32768; end
      1: begin r = (a * 2) % 65536 + c;         co = a / 32768; end
      2: begin r = a / 2 + (a % 2) * 32768;     co = a % 2;     end
      3: begin r = a / 2 + c * 32768;           co = a % 2;     end
      4, 5: begin r = (a * 2) % 65536;          co = a / 32768; end
      6: begin r = a / 2 + (a / 32768) * 32768; co = a % 2;     end
      7: begin r = a / 2;                       co = a % 2;     end
      8: begin r = 65535 - a; end
      9: begin r = (65536 - a) % 65536; co = (a != 0) ? 1 : 0; v = (a == 32768) ? 1 : 0; end
      10, 11: w = 0;
      12: w = 0;
      13: r = (b == 1) ? a - p : a + p;
      14: r = (b == 1) ? a - p : a;
      default: r = (b == 1) ? a : a + p;
    endcase
    if (op == 12) begin
      z = (b == 0) ? 1 : 0; s = 0;
    end else begin
      z = (r == 0) ? 1 : 0; s = r / 32768;
    end
    return {16'(r), 1'(co), 1'(z), 1'(s), 1'(v), 1'(w)};
  endfunction

  task automatic check(string tag, logic [20:0] got, logic [20:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%0h opd=%h cin=%0b idx=%0d got=%h exp=%h",
               tag, op_i, opd_i, cin_i, idx_i, got, exp);
    end
  endtask

  function automatic logic [20:0] outs();
    return {res_o, cout_o, zero_o, sign_o, ovf_o, wr_en_o};
  endfunction

  task automatic run_op(int op, int a, int c, int ix, bit hold_check);
    logic [20:0] exp, snap;
    @(negedge clk);
    in_vld_i = 1'b1; op_i = 4'(op); opd_i = 16'(a); cin_i = 1'(c); idx_i = 4'(ix);
    exp = model(op, a, c, ix);
    @(negedge clk);
    in_vld_i = 1'b0;
    check(tag_of(op), outs(), exp);
    // R2: valid one cycle after request
    check("R2", {20'd0, out_vld_o}, 21'd1);
    if (hold_check) begin
      snap  = outs();
      opd_i = ~opd_i; op_i = ~op_i; cin_i = ~cin_i;
      @(negedge clk);
      // R2: idle cycle keeps result, drops valid
      check("R2", {res_o, cout_o, zero_o, sign_o, ovf_o, out_vld_o},
            {snap[20:1], 1'b0});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int corners [8] = '{0, 1, 32768, 32767, 65535, 2, 65534, 16384};
    rst_n = 1'b0; in_vld_i = 1'b0; op_i = '0; opd_i = 16'hFFFF; cin_i = 1'b1; idx_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {outs(), out_vld_o}, 22'd0);
    rst_n = 1'b1;
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 264; k++) begin
        int a, c, ix;
        a  = (k < 256) ? ((k * 40503) ^ (k * 257)) % 65536 : corners[k - 256];
        c  = (k % 2) ^ ((k / 4) % 2);
        ix = (k * 7) % 16;
        run_op(op, a, c, ix, (k % 16) == 0);
      end
    end
    // R8: negate of zero clears carry; R11 zero flag set
    run_op(9, 0, 1, 0, 1'b0);
    // R10: index extremes
    run_op(15, 0, 0, 15, 1'b0);
    run_op(14, 65535, 1, 0, 1'b0);
    // R5: both left shifts of the same operand agree
    run_op(4, 51234, 1, 0, 1'b0);
    run_op(5, 51234, 1, 0, 1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule